// File: doc/BRIEF.md
# SPI Master Control and Status Register Front End

This block is the register side of an SPI master. A 32-bit word-addressed bus reaches four storage words: a control word, a status word, a 9-bit baud divisor and a second control word that holds the fault-interrupt enables. A companion shift engine supplies FIFO fill levels, a busy indication and single-cycle error events. It receives the control, baud and enable words, plus read and write strobes for the data buffer word.

Control and control2 can each be changed through three extra alias addresses. On an alias, every 1 bit clears, sets or toggles the matching bit, so that software can change one field without a read-modify-write. The status word carries three sticky error flags and live FIFO fields. Software clears the sticky flags only through the status clear alias. Three registered, level-sensitive interrupt lines are derived from selectable FIFO-level conditions and from the enabled error flags.

Top module: `spi_csr_front`

## Requirements
- R1: During and after reset, control, control2 and baud read as zero, and all three interrupt outputs are low while reset is asserted.
- R2: Word address 0 writes control directly. Addresses 1, 2 and 3 act as clear, set and invert aliases, in which each 1 bit clears, sets or toggles the matching control bit and each 0 bit leaves it unchanged. Addresses 16 to 19 do the same for control2. A read of any alias returns the base register value.
- R3: Control bits [1:0] select the receive interrupt condition: 0 gives receive level equal to 0, 1 gives level not 0, 2 gives level at least half the FIFO depth, and 3 gives level equal to the depth. The line follows one clock after its inputs.
- R4: Control bits [3:2] select the transmit interrupt condition: 0 gives transmit level 0 with the shifter idle, 1 gives transmit level 0, 2 gives at least half the depth free, and 3 gives at least one slot free. The line follows one clock after its inputs.
- R5: Status bit 6 (receive overflow), bit 8 (transmit underrun) and bit 12 (frame error) are sticky. An error event sets its flag. Only a write of 1 to that bit at the status clear alias (address 5) clears it, and an event in the same cycle as the clear wins.
- R6: A status read returns bit 5 set when the receive level is 0, the transmit level in bits [20:16] and the receive level in bits [28:24].
- R7: Writes to status address 4 and to its set and invert aliases (6, 7) have no effect on any status bit.
- R8: The baud register at address 12 keeps only bits [8:0] of a write, and reads back zero above bit 8.
- R9: The fault interrupt is high, one clock after the flags, when the underrun flag is set with control2 bit 10, the overflow flag with bit 11, or the frame error flag with bit 12.
- R10: A bus access to address 8 raises the buffer write or read strobe in the same cycle, passes the write data, and returns the engine's buffer word. Addresses 9 to 11 and 13 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| rx_level_i | input | 5 | Receive FIFO fill level |
| tx_busy_i | input | 1 | Shift register still holds a word |
| rx_ovf_evt_i | input | 1 | Receive overflow event pulse |
| tx_udr_evt_i | input | 1 | Transmit underrun event pulse |
| frm_err_evt_i | input | 1 | Frame error event pulse |
| buf_rdata_i | input | 32 | Word read from the receive FIFO |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wdata_o | output | 32 | Word for the transmit FIFO |
| ctrl_o | output | 32 | Control word |
| ctrl2_o | output | 32 | Second control word |
| baud_o | output | 9 | Baud divisor |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |
| fault_irq_o | output | 1 | Fault interrupt |

## Verification
A corrupted alias operation shows at the next read of the base address, one cycle after the write. It shows as a changed bit outside the written mask or as an unchanged bit inside it. A wrong threshold decode or a lost sticky flag appears on the interrupt pins one clock after the level or event, so each mode is checked at the boundary level where its condition flips. Ignored status writes and same-cycle event-versus-clear races are checked by reading the status word back straight after the write.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } alias_op_e;

  // addr[4:2] selects a four-word group
  localparam logic [2:0] GRP_CTRL  = 3'd0;
  localparam logic [2:0] GRP_STAT  = 3'd1;
  localparam logic [2:0] GRP_BUF   = 3'd2;
  localparam logic [2:0] GRP_BAUD  = 3'd3;
  localparam logic [2:0] GRP_CTRL2 = 3'd4;

  localparam int unsigned BAUD_W = 9;

  // sticky flag index: 0 overflow, 1 underrun, 2 frame error
  localparam int unsigned NFLAG = 3;
  function automatic int unsigned flag_pos(int unsigned idx);
    case (idx)
      0:       return 6;
      1:       return 8;
      default: return 12;
    endcase
  endfunction
  function automatic int unsigned flag_en_pos(int unsigned idx);
    case (idx)
      0:       return 11;
      1:       return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/spi_csr_alias_reg.sv
module spi_csr_alias_reg
  import spi_csr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    unique case (op_i)
      OP_WR:   q_d = wdata_i;
      OP_CLR:  q_d = q_q & ~wdata_i;
      OP_SET:  q_d = q_q | wdata_i;
      default: q_d = q_q ^ wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= q_d;
  end

  assign q_o = q_q;

  // R2: alias ops touch only bits written as 1
  a_r2_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i != OP_WR |=> ((q_o ^ $past(q_o)) & ~$past(wdata_i)) == '0);
  a_r2_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_CLR |=> (q_o & $past(wdata_i)) == '0);
  a_r2_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_SET |=> (q_o & $past(wdata_i)) == $past(wdata_i));
  a_r2_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op_i == OP_INV |=> ((q_o ^ $past(q_o)) == $past(wdata_i)));
endmodule

// File: rtl/spi_csr_status.sv
module spi_csr_status
  import spi_csr_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_we_i,
  input  logic [NFLAG-1:0]  clr_mask_i,
  input  logic [NFLAG-1:0]  evt_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic [NFLAG-1:0]  flag_o,
  output logic [DATA_W-1:0] status_o
);
  logic [NFLAG-1:0] flag_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         flag_q[g] <= 1'b0;
      else if (evt_i[g])                   flag_q[g] <= 1'b1;
      else if (clr_we_i && clr_mask_i[g])  flag_q[g] <= 1'b0;
    end

    // R5: flag stays until cleared by a 1 at the clear alias
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[g] && !(clr_we_i && clr_mask_i[g]) |=> flag_q[g]);
    a_r5_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_o[g]);
  end

  always_comb begin
    status_o        = '0;
    status_o[5]     = (rx_level_i == '0);
    for (int i = 0; i < NFLAG; i++) status_o[flag_pos(i)] = flag_q[i];
    status_o[20:16] = 5'(tx_level_i);
    status_o[28:24] = 5'(rx_level_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_csr_irq.sv
module spi_csr_irq
  import spi_csr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       rx_sel_i,
  input  logic [1:0]       tx_sel_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic             tx_busy_i,
  input  logic [NFLAG-1:0] err_flag_i,
  input  logic [NFLAG-1:0] err_en_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o,
  output logic             fault_irq_o
);
  localparam logic [LVL_W:0] DEPTH_V = (LVL_W+1)'(DEPTH);
  localparam logic [LVL_W:0] HALF_V  = (LVL_W+1)'(DEPTH / 2);

  logic [LVL_W:0] rx_lvl, tx_free;
  logic rx_cond, tx_cond;
  logic rx_q, tx_q, fault_q;

  assign rx_lvl  = {1'b0, rx_level_i};
  assign tx_free = DEPTH_V - {1'b0, tx_level_i};

  always_comb begin
    unique case (rx_sel_i)
      2'd0:    rx_cond = (rx_lvl == '0);
      2'd1:    rx_cond = (rx_lvl != '0);
      2'd2:    rx_cond = (rx_lvl >= HALF_V);
      default: rx_cond = (rx_lvl >= DEPTH_V);
    endcase
    unique case (tx_sel_i)
      2'd0:    tx_cond = (tx_free == DEPTH_V) && !tx_busy_i;
      2'd1:    tx_cond = (tx_free == DEPTH_V);
      2'd2:    tx_cond = (tx_free >= HALF_V);
      default: tx_cond = (tx_free != '0);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= 1'b0;
      tx_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      rx_q    <= rx_cond;
      tx_q    <= tx_cond;
      fault_q <= |(err_flag_i & err_en_i);
    end
  end

  assign rx_irq_o    = rx_q;
  assign tx_irq_o    = tx_q;
  assign fault_irq_o = fault_q;

  a_r3_rx_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sel_i == 2'd3 && rx_level_i == LVL_W'(DEPTH) |=> rx_irq_o);
  a_r3_rx_empty_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sel_i == 2'd1 && rx_level_i == '0 |=> !rx_irq_o);
  a_r4_tx_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sel_i == 2'd0 && tx_busy_i |=> !tx_irq_o);
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_en_i == '0 |=> !fault_irq_o);
endmodule

// File: rtl/spi_csr_front.sv
module spi_csr_front
  import spi_csr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_busy_i,
  input  logic              rx_ovf_evt_i,
  input  logic              tx_udr_evt_i,
  input  logic              frm_err_evt_i,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              buf_wr_o,
  output logic              buf_rd_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] ctrl2_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              fault_irq_o
);
  logic [2:0]        grp;
  alias_op_e         op;
  logic              wr, rd;
  logic [DATA_W-1:0] status;
  logic [NFLAG-1:0]  flags, clr_mask, err_en;
  logic [BAUD_W-1:0] baud_q;

  assign grp = addr_i[4:2];
  assign op  = alias_op_e'(addr_i[1:0]);
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  spi_csr_alias_reg #(.W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .we_i   (wr && grp == GRP_CTRL),
    .op_i   (op),
    .wdata_i(wdata_i),
    .q_o    (ctrl_o)
  );

  spi_csr_alias_reg #(.W(DATA_W)) u_ctrl2 (
    .clk_i, .rst_ni,
    .we_i   (wr && grp == GRP_CTRL2),
    .op_i   (op),
    .wdata_i(wdata_i),
    .q_o    (ctrl2_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    baud_q <= '0;
    else if (wr && grp == GRP_BAUD && op == OP_WR)  baud_q <= wdata_i[BAUD_W-1:0];
  end
  assign baud_o = baud_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_map
    assign clr_mask[g] = wdata_i[flag_pos(g)];
    assign err_en[g]   = ctrl2_o[flag_en_pos(g)];
  end

  spi_csr_status #(.LVL_W(LVL_W)) u_status (
    .clk_i, .rst_ni,
    .clr_we_i  (wr && grp == GRP_STAT && op == OP_CLR),
    .clr_mask_i(clr_mask),
    .evt_i     ({frm_err_evt_i, tx_udr_evt_i, rx_ovf_evt_i}),
    .tx_level_i(tx_level_i),
    .rx_level_i(rx_level_i),
    .flag_o    (flags),
    .status_o  (status)
  );

  spi_csr_irq #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_irq (
    .clk_i, .rst_ni,
    .rx_sel_i   (ctrl_o[1:0]),
    .tx_sel_i   (ctrl_o[3:2]),
    .rx_level_i (rx_level_i),
    .tx_level_i (tx_level_i),
    .tx_busy_i  (tx_busy_i),
    .err_flag_i (flags),
    .err_en_i   (err_en),
    .rx_irq_o   (rx_irq_o),
    .tx_irq_o   (tx_irq_o),
    .fault_irq_o(fault_irq_o)
  );

  assign buf_wr_o    = wr && grp == GRP_BUF && op == OP_WR;
  assign buf_rd_o    = rd && grp == GRP_BUF && op == OP_WR;
  assign buf_wdata_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    unique case (grp)
      GRP_CTRL:  rdata_o = ctrl_o;
      GRP_STAT:  rdata_o = status;
      GRP_BUF:   if (op == OP_WR) rdata_o = buf_rdata_i;
      GRP_BAUD:  if (op == OP_WR) rdata_o = DATA_W'(baud_q);
      GRP_CTRL2: rdata_o = ctrl2_o;
      default:   rdata_o = '0;
    endcase
  end

  a_r8_baud_trunc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && grp == GRP_BAUD && op == OP_WR |=> baud_o == $past(wdata_i[BAUD_W-1:0]));
  a_r9_fault_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[0] && ctrl2_o[11] |=> fault_irq_o);
  a_r7_stat_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && grp == GRP_STAT && op != OP_CLR && flags[1] |=> flags[1]);
  a_r1_irq_reset: assert final (rst_ni || (!rx_irq_o && !tx_irq_o && !fault_irq_o));
endmodule

// File: tb/spi_csr_front_tb_top.sv
`timescale 1ns/1ps
module spi_csr_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic        tx_busy = 1'b0, ovf_evt = 1'b0, udr_evt = 1'b0, frm_evt = 1'b0;
  logic [31:0] buf_rdata = 32'hA5C3_0F1E;
  logic        buf_wr, buf_rd;
  logic [31:0] buf_wdata, ctrl, ctrl2;
  logic [8:0]  baud;
  logic        rx_irq, tx_irq, fault_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_csr_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_busy_i(tx_busy), .rx_ovf_evt_i(ovf_evt), .tx_udr_evt_i(udr_evt),
    .frm_err_evt_i(frm_evt), .buf_rdata_i(buf_rdata), .buf_wr_o(buf_wr),
    .buf_rd_o(buf_rd), .buf_wdata_o(buf_wdata), .ctrl_o(ctrl), .ctrl2_o(ctrl2),
    .baud_o(baud), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .fault_irq_o(fault_irq)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1;
    chk("R1 irq in reset", {29'b0, rx_irq, tx_irq, fault_irq}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_rd(5'd0, d);  chk("R1 ctrl", d, 32'h0);
    bus_rd(5'd16, d); chk("R1 ctrl2", d, 32'h0);
    bus_rd(5'd12, d); chk("R1 baud", d, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    bus_wr(5'd0, 32'h0000_00F0); bus_rd(5'd0, d); chk("R2 base write", d, 32'h0000_00F0);
    bus_wr(5'd1, 32'h0000_0030); bus_rd(5'd0, d); chk("R2 clear", d, 32'h0000_00C0);
    bus_wr(5'd2, 32'h8001_0000); bus_rd(5'd0, d); chk("R2 set", d, 32'h8001_00C0);
    bus_wr(5'd3, 32'h0000_0041); bus_rd(5'd0, d); chk("R2 invert", d, 32'h8001_0081);
    for (int a = 1; a < 4; a++) begin
      bus_rd(5'(a), d); chk("R2 alias read", d, 32'h8001_0081);
    end
    bus_wr(5'd18, 32'h0000_1C00); bus_rd(5'd16, d); chk("R2 ctrl2 set", d, 32'h0000_1C00);
    bus_wr(5'd19, 32'h0000_0400); bus_rd(5'd17, d); chk("R2 ctrl2 invert", d, 32'h0000_1800);
    bus_wr(5'd17, 32'hFFFF_FFFF); bus_rd(5'd16, d); chk("R2 ctrl2 clear", d, 32'h0);
  endtask

  task automatic t_baud();
    logic [31:0] d;
    bus_wr(5'd12, 32'hFFFF_FFFF); bus_rd(5'd12, d); chk("R8 baud truncate", d, 32'h0000_01FF);
    bus_wr(5'd12, 32'h0000_0A2B); bus_rd(5'd12, d); chk("R8 baud value", d, 32'h0000_002B);
  endtask

  task automatic rx_case(input logic [1:0] m, input logic [4:0] lvl, input logic exp, input string tag);
    bus_wr(5'd0, {30'b0, m});
    rx_level = lvl;
    settle();
    chk(tag, {31'b0, rx_irq}, {31'b0, exp});
  endtask

  task automatic t_rx_irq();
    rx_case(2'd0, 5'd0,  1'b1, "R3 mode0 empty");
    rx_case(2'd0, 5'd1,  1'b0, "R3 mode0 not empty");
    rx_case(2'd1, 5'd0,  1'b0, "R3 mode1 empty");
    rx_case(2'd1, 5'd7,  1'b1, "R3 mode1 level7");
    rx_case(2'd2, 5'd7,  1'b0, "R3 mode2 below half");
    rx_case(2'd2, 5'd8,  1'b1, "R3 mode2 half");
    rx_case(2'd3, 5'd15, 1'b0, "R3 mode3 one short");
    rx_case(2'd3, 5'd16, 1'b1, "R3 mode3 full");
    rx_level = 5'd0;
  endtask

  task automatic tx_case(input logic [1:0] m, input logic [4:0] lvl, input logic busy,
                         input logic exp, input string tag);
    bus_wr(5'd0, {28'b0, m, 2'b00});
    tx_level = lvl; tx_busy = busy;
    settle();
    chk(tag, {31'b0, tx_irq}, {31'b0, exp});
  endtask

  task automatic t_tx_irq();
    tx_case(2'd0, 5'd0,  1'b1, 1'b0, "R4 mode0 busy");
    tx_case(2'd0, 5'd0,  1'b0, 1'b1, "R4 mode0 idle");
    tx_case(2'd1, 5'd0,  1'b1, 1'b1, "R4 mode1 busy");
    tx_case(2'd1, 5'd1,  1'b0, 1'b0, "R4 mode1 one queued");
    tx_case(2'd2, 5'd8,  1'b0, 1'b1, "R4 mode2 half free");
    tx_case(2'd2, 5'd9,  1'b0, 1'b0, "R4 mode2 below half");
    tx_case(2'd3, 5'd15, 1'b0, 1'b1, "R4 mode3 one free");
    tx_case(2'd3, 5'd16, 1'b0, 1'b0, "R4 mode3 full");
    tx_level = 5'd0; tx_busy = 1'b0;
  endtask

  task automatic t_status();
    logic [31:0] d;
    tx_level = 5'd10; rx_level = 5'd3;
    bus_rd(5'd4, d); chk("R6 levels", d, 32'h030A_0000);
    rx_level = 5'd0;
    bus_rd(5'd4, d); chk("R6 rx empty bit", d, 32'h000A_0020);
    bus_wr(5'd4, 32'hFFFF_FFFF);
    bus_wr(5'd6, 32'hFFFF_FFFF);
    bus_rd(5'd4, d); chk("R7 base and set ignored", d, 32'h000A_0020);
    tx_level = 5'd0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ovf_evt = 1'b1;
      1: udr_evt = 1'b1;
      default: frm_evt = 1'b1;
    endcase
    @(negedge clk);
    ovf_evt = 1'b0; udr_evt = 1'b0; frm_evt = 1'b0;
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(0);
    repeat (3) @(negedge clk);
    bus_rd(5'd4, d); chk("R5 overflow sticky", d & 32'h1140, 32'h0000_0040);
    bus_wr(5'd7, 32'h0000_1140);
    bus_rd(5'd4, d); chk("R7 invert ignored", d & 32'h1140, 32'h0000_0040);
    bus_wr(5'd5, 32'h0000_0100);
    bus_rd(5'd4, d); chk("R5 clear other bit only", d & 32'h1140, 32'h0000_0040);
    bus_wr(5'd5, 32'h0000_0040);
    bus_rd(5'd4, d); chk("R5 overflow cleared", d & 32'h1140, 32'h0);
    // event and clear in the same cycle: event wins
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 5'd5; wdata = 32'h0000_1000; frm_evt = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; frm_evt = 1'b0;
    bus_rd(5'd4, d); chk("R5 event beats clear", d & 32'h1140, 32'h0000_1000);
    settle();
    chk("R9 frame masked", {31'b0, fault_irq}, 32'h0);
    bus_wr(5'd18, 32'h0000_1000); settle();
    chk("R9 frame enabled", {31'b0, fault_irq}, 32'h1);
    bus_wr(5'd5, 32'h0000_1000); settle();
    chk("R9 frame cleared", {31'b0, fault_irq}, 32'h0);
    pulse(1); settle();
    chk("R9 underrun not enabled", {31'b0, fault_irq}, 32'h0);
    bus_wr(5'd18, 32'h0000_0400); settle();
    chk("R9 underrun enabled", {31'b0, fault_irq}, 32'h1);
    bus_wr(5'd5, 32'h0000_0100);
    pulse(0); settle();
    chk("R9 overflow not enabled", {31'b0, fault_irq}, 32'h0);
    bus_wr(5'd18, 32'h0000_0800); settle();
    chk("R9 overflow enabled", {31'b0, fault_irq}, 32'h1);
    bus_wr(5'd5, 32'h0000_1140);
    bus_wr(5'd17, 32'hFFFF_FFFF);
  endtask

  task automatic t_map();
    logic [31:0] d;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 5'd8;
    #1;
    chk("R10 buffer read data", rdata, 32'hA5C3_0F1E);
    chk("R10 read strobe", {30'b0, buf_rd, buf_wr}, 32'h2);
    we = 1'b1; wdata = 32'h1234_5678;
    #0.5;
    chk("R10 write strobe", {30'b0, buf_rd, buf_wr}, 32'h1);
    chk("R10 write data", buf_wdata, 32'h1234_5678);
    req = 1'b0; we = 1'b0;
    for (int a = 9; a < 16; a++) begin
      if (a != 12) begin
        bus_rd(5'(a), d); chk("R10 reserved reads zero", d, 32'h0);
      end
    end
  endtask

  initial begin
    t_reset();
    t_alias();
    t_baud();
    t_rx_irq();
    t_tx_irq();
    t_status();
    t_sticky();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule